// File: doc/BRIEF.md
# Synchronization Counter Image Encoder

This block turns an initial rolling-code counter value into the six-byte image that a programmer writes into nonvolatile memory at offsets 18h through 1Dh. A single start strobe captures the mode (16-bit or 20-bit counter), the counter value and, in 16-bit mode, an overflow count. From these the block forms three counter bytes A (most significant), B and C (least significant).

The bytes are then scrambled into a pseudo-Gray image. C is inverted whenever the original B is odd, and B is inverted whenever A is odd. Three pairwise XOR checksums are computed from the scrambled bytes. The block then streams six address/data pairs to a memory writer through a valid/ready handshake. A one-cycle done pulse marks the end of the stream.

Top module: `ctr_image_encoder`

## Requirements
- R1: With wideMode=1, the unscrambled bytes are A = {4'b0000, counterIn[19:16]}, B = counterIn[15:8] and C = counterIn[7:0]. A[7:6] and A[5:4] are always zero.
- R2: With wideMode=0, A[7:2] is zero and counterIn[19:16] is ignored. A[1:0] encodes overflowCnt: 0 gives 2'b11, 1 gives 2'b01, and 2 or 3 give 2'b00.
- R3: C is replaced by C xor FFh exactly when bit 0 of the unscrambled B is 1.
- R4: B is replaced by B xor FFh exactly when bit 0 of A is 1. The decision for C in R3 uses B as it was before this inversion.
- R5: Each checksum is taken over the scrambled bytes: sum1 = B xor C, sum2 = A xor C, sum3 = A xor B.
- R6: The stream presents six address/data pairs in this order: 18h with A, 19h with B, 1Ah with C, 1Bh with sum1, 1Ch with sum3, 1Dh with sum2. outAddr never leaves 18h..1Dh while outValid is high.
- R7: A pair is consumed only in a cycle where outValid and outReady are both high. While outReady is low, outValid, outAddr and outData hold their values.
- R8: done is high for exactly one cycle, the cycle after the sixth pair is consumed. outValid is low in that cycle.
- R9: A start that arrives while a stream is in progress, including the cycle in which the sixth pair is consumed, is ignored. It changes neither the remaining pairs nor what follows.
- R10: After reset, outValid and done are low.
- R11: A start sampled while idle, including in the done cycle, captures the inputs at that edge. outValid rises in the next cycle with the 18h pair, and later changes on the inputs have no effect.
- R12: A 16-bit counter of 0000h with overflow count 0 yields 03, FF, 00, FF, FC, 03. A 20-bit counter of FABCDh yields 0F, 54, 32, 66, 5B, 3D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture inputs and begin a stream (idle only) |
| wideMode | input | 1 | 1 = 20-bit counter, 0 = 16-bit counter with overflow |
| counterIn | input | 20 | Initial counter value |
| overflowCnt | input | 2 | Overflow count, used in 16-bit mode |
| outValid | output | 1 | An address/data pair is presented |
| outReady | input | 1 | Consumer accepts the presented pair |
| outAddr | output | 8 | Memory offset of the presented byte |
| outData | output | 8 | Byte to store at outAddr |
| done | output | 1 | One-cycle pulse after the last pair |

## Verification
Two events can land in the same cycle: the handshake that consumes the sixth pair and a new start. A start in that cycle must be discarded. A start one cycle later, during the done pulse, must be taken. The bench raises start at random points inside streams, including on the final accepted beat, and checks two things: the idle cycle that follows must show no outValid, and the pairs already under way must still match the values the bench computes itself. It also chains jobs by raising start exactly in the done cycle, and checks that the next 18h pair appears one cycle later carrying the new job's image.

// File: rtl/ctr_image_pkg.sv
package ctr_image_pkg;

  localparam int BYTE_W    = 8;
  localparam int NUM_SLOTS = 6;
  localparam int SLOT_IDX_W = $clog2(NUM_SLOTS);

  // strobes the control issues to the datapath
  typedef struct packed {
    logic capture;  // register a new image from the inputs
    logic advance;  // current pair consumed
  } ctrlStrobeT;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_STREAM = 1'b1
  } streamStateT;

  // overflow count to the two-bit code kept in A[1:0]
  function automatic logic [1:0] encodeOverflow(input logic [1:0] cnt);
    case (cnt)
      2'd0:    return 2'b11;
      2'd1:    return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/ctr_image_datapath.sv
module ctr_image_datapath
  import ctr_image_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobeT            strb,
  input  logic                  wideMode,
  input  logic [CNT_W-1:0]      counterIn,
  input  logic [1:0]            overflowCnt,
  input  logic [SLOT_IDX_W-1:0] slotIdx,
  output logic [BYTE_W-1:0]     slotData
);

  localparam int HI_W  = CNT_W - 2 * BYTE_W;  // counter bits above B
  localparam int PAD_W = BYTE_W - HI_W;

  logic [BYTE_W-1:0] rawA, rawB, rawC;
  logic [BYTE_W-1:0] grayB, grayC;
  logic [BYTE_W-1:0] nextImg [NUM_SLOTS];
  logic [BYTE_W-1:0] img     [NUM_SLOTS];

  // split the counter into bytes
  always_comb begin
    if (wideMode)
      rawA = {{PAD_W{1'b0}}, counterIn[CNT_W-1 -: HI_W]};
    else
      rawA = {{(BYTE_W-2){1'b0}}, encodeOverflow(overflowCnt)};
    rawB = counterIn[2*BYTE_W-1 -: BYTE_W];
    rawC = counterIn[BYTE_W-1:0];
  end

  // chained inversion: C follows raw B, B follows A
  always_comb begin
    grayC = rawB[0] ? ~rawC : rawC;
    grayB = rawA[0] ? ~rawB : rawB;
  end

  // slot order matches the stored layout
  always_comb begin
    nextImg[0] = rawA;
    nextImg[1] = grayB;
    nextImg[2] = grayC;
    nextImg[3] = grayB ^ grayC;
    nextImg[4] = rawA ^ grayB;
    nextImg[5] = rawA ^ grayC;
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        img[s] <= '0;
      else if (strb.capture)
        img[s] <= nextImg[s];
    end

    // R9: the image only changes on a capture
    assert_image_frozen_R9: assert property (
      @(posedge clk) disable iff (!rstN)
      !strb.capture |=> $stable(img[s]));
  end

  always_comb begin
    slotData = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (slotIdx == SLOT_IDX_W'(s))
        slotData = img[s];
  end

endmodule

// File: rtl/ctr_image_ctrl.sv
module ctr_image_ctrl
  import ctr_image_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  outReady,
  output ctrlStrobeT            strb,
  output logic                  outValid,
  output logic [SLOT_IDX_W-1:0] slotIdx,
  output logic                  done
);

  localparam logic [SLOT_IDX_W-1:0] LAST_IDX = SLOT_IDX_W'(NUM_SLOTS - 1);

  streamStateT state;
  logic [SLOT_IDX_W-1:0] idx;
  logic lastBeat;

  always_comb begin
    strb.capture = (state == ST_IDLE) && start;
    strb.advance = (state == ST_STREAM) && outReady;
    lastBeat     = (idx == LAST_IDX);
    outValid     = (state == ST_STREAM);
    slotIdx      = idx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_STREAM;
            idx   <= '0;
          end
        end
        ST_STREAM: begin
          if (strb.advance) begin
            if (lastBeat) begin
              state <= ST_IDLE;
              idx   <= '0;
              done  <= 1'b1;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: presented pair holds while the consumer stalls
  assert_hold_R7: assert property (
    @(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(slotIdx)));

  // R8: done lasts one cycle
  assert_done_pulse_R8: assert property (
    @(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: done only after the last pair was consumed
  assert_done_cause_R8: assert property (
    @(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(outValid && outReady && lastBeat) && !outValid));

  // R9: start during a stalled stream moves nothing
  assert_start_ignored_R9: assert property (
    @(posedge clk) disable iff (!rstN)
    (outValid && start && !outReady) |=> (outValid && $stable(idx)));

endmodule

// File: rtl/ctr_image_encoder.sv
module ctr_image_encoder
  import ctr_image_pkg::*;
#(
  parameter int                CNT_W     = 20,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              wideMode,
  input  logic [CNT_W-1:0]  counterIn,
  input  logic [1:0]        overflowCnt,
  output logic              outValid,
  input  logic              outReady,
  output logic [ADDR_W-1:0] outAddr,
  output logic [BYTE_W-1:0] outData,
  output logic              done
);

  localparam logic [ADDR_W-1:0] END_ADDR = BASE_ADDR + ADDR_W'(NUM_SLOTS);

  ctrlStrobeT            strb;
  logic [SLOT_IDX_W-1:0] slotIdx;

  ctr_image_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .outReady (outReady),
    .strb     (strb),
    .outValid (outValid),
    .slotIdx  (slotIdx),
    .done     (done)
  );

  ctr_image_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wideMode    (wideMode),
    .counterIn   (counterIn),
    .overflowCnt (overflowCnt),
    .slotIdx     (slotIdx),
    .slotData    (outData)
  );

  assign outAddr = BASE_ADDR + ADDR_W'(slotIdx);

  // R6: addresses stay inside the six-byte window
  assert_addr_window_R6: assert property (
    @(posedge clk) disable iff (!rstN)
    outValid |-> (outAddr >= BASE_ADDR && outAddr < END_ADDR));

  // R7: data stable under stall
  assert_data_hold_R7: assert property (
    @(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outData));

endmodule

// File: tb/ctr_image_encoder_bench.sv
module ctr_image_encoder_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic wideMode = 1'b0;
  logic [19:0] counterIn = '0;
  logic [1:0] overflowCnt = '0;
  logic outReady = 1'b0;
  logic outValid, done;
  logic [7:0] outAddr, outData;

  int checks = 0;
  int fails = 0;
  int seed = 32'h5eed_1234;

  always #2 clk = ~clk;

  ctr_image_encoder u_ctr_image_encoder (
    .clk(clk), .rstN(rstN), .start(start), .wideMode(wideMode),
    .counterIn(counterIn), .overflowCnt(overflowCnt),
    .outValid(outValid), .outReady(outReady),
    .outAddr(outAddr), .outData(outData), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0][7:0] refImage(input logic wide, input logic [19:0] c,
                                               input logic [1:0] ov);
    logic [7:0] a, b, cc;
    logic [5:0][7:0] e;
    if (wide) a = {4'h0, c[19:16]};                  // R1
    else a = {6'b0, (ov == 2'd0) ? 2'b11 : (ov == 2'd1) ? 2'b01 : 2'b00}; // R2
    b = c[15:8];
    cc = c[7:0];
    if (b[0]) cc = cc ^ 8'hFF;                        // R3
    if (a[0]) b = b ^ 8'hFF;                          // R4
    e[0] = a; e[1] = b; e[2] = cc;
    e[3] = b ^ cc; e[4] = a ^ b; e[5] = a ^ cc;       // R5, R6 order
    return e;
  endfunction

  // Raises start at the current negedge, streams the job and returns at the
  // negedge of the done cycle.
  task automatic runJob(input logic wide, input logic [19:0] c, input logic [1:0] ov,
                        input bit injectStart, input bit stallMore, input string tag);
    logic [5:0][7:0] exp;
    int beat;
    int wait_n;
    exp = refImage(wide, c, ov);
    start = 1'b1; wideMode = wide; counterIn = c; overflowCnt = ov; outReady = 1'b0;
    @(negedge clk);
    start = 1'b0;
    wideMode = $urandom() % 2; counterIn = 20'($urandom()); overflowCnt = 2'($urandom());
    beat = 0;
    wait_n = 0;
    while (beat < 6) begin
      check({tag, " R7 valid"}, outValid, 1'b1);
      check({tag, " R6 addr"}, outAddr, 8'h18 + beat[7:0]);
      check({tag, " R6 data"}, outData, exp[beat]);
      outReady = (wait_n > 6) ? 1'b1 : (stallMore ? ($urandom() % 3 == 0) : ($urandom() % 4 != 0));
      start = injectStart && (($urandom() % 2 == 0) || beat == 5);  // R9
      if (start) begin
        wideMode = $urandom() % 2; counterIn = 20'($urandom()); overflowCnt = 2'($urandom());
      end
      if (outReady) begin beat++; wait_n = 0; end
      else wait_n++;
      @(negedge clk);
      start = 1'b0;
      outReady = 1'b0;
    end
    check({tag, " R8 done"}, done, 1'b1);
    check({tag, " R8 valid low"}, outValid, 1'b0);
  endtask

  task automatic idleCheck(input string tag);
    @(negedge clk);
    check({tag, " R9/R8 idle valid"}, outValid, 1'b0);
    check({tag, " R8 done single"}, done, 1'b0);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R10 valid at reset", outValid, 1'b0);
    check("R10 done at reset", done, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 valid after reset", outValid, 1'b0);

    // R12 directed examples
    runJob(1'b0, 20'h00000, 2'd0, 1'b0, 1'b0, "R12 ex16");
    idleCheck("R12 ex16");
    runJob(1'b1, 20'hFABCD, 2'd0, 1'b0, 1'b0, "R12 ex20");
    idleCheck("R12 ex20");
    // R2 overflow once/twice/three, high counter bits ignored
    runJob(1'b0, 20'hF1234, 2'd1, 1'b0, 1'b0, "R2 once");
    idleCheck("R2 once");
    runJob(1'b0, 20'h5789A, 2'd2, 1'b0, 1'b0, "R2 twice");
    idleCheck("R2 twice");
    runJob(1'b0, 20'hA00FF, 2'd3, 1'b0, 1'b0, "R2 three");
    idleCheck("R2 three");
    // R3/R4 corners: odd B with odd A, all ones
    runJob(1'b1, 20'h1FF01, 2'd0, 1'b0, 1'b1, "R4 oddA");
    idleCheck("R4 oddA");
    runJob(1'b1, 20'hFFFFF, 2'd0, 1'b0, 1'b1, "R3 ones");
    // R11: start in the done cycle is accepted
    runJob(1'b1, 20'h2468A, 2'd0, 1'b0, 1'b0, "R11 chain");
    idleCheck("R11 chain");
    // R9: start during streams, including the final beat
    for (int j = 0; j < 40; j++) begin
      runJob($urandom() % 2, 20'($urandom()), 2'($urandom()), 1'b1, j % 3 == 0, "R9 rand");
      idleCheck("R9 rand");
    end
    // random chains through the done cycle
    for (int j = 0; j < 20; j++)
      runJob($urandom() % 2, 20'($urandom()), 2'($urandom()), 1'b0, 1'b0, "R11 rand");
    idleCheck("R11 tail");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule